// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block produces the four gate timing signals for a full-bridge DC/DC converter whose output power is controlled by the phase offset between its two legs. Each leg switches at a fixed 50% duty. The leading leg starts high at the beginning of every switching period. The lagging leg follows the same pattern, shifted later by a programmable number of count-clock cycles. The switching period is a build-time parameter. The default is 500 counts, which gives 200 kHz from a 100 MHz count clock.

Each leg has its own dead-band value. It delays only the rising edge of that leg's high-side and low-side signals, so the switch-node voltage can swing to zero before the opposite device turns on. The phase and both dead-band values are taken in only when a new period starts. A one-cycle trigger marks that same instant, so that sampling and the control update can be aligned to the bridge.

When the enable input is low, the four gate outputs and the trigger are held low. The next enabled cycle begins a fresh period at position zero.

Top module: `psfb_pwm`

## Requirements
- R1: While enable is high, the internal position steps 0, 1, …, PERIOD−1 and then back to 0. The output `sync_trig` is high for exactly the cycles in which the position is 0. This includes the first enabled cycle after an idle spell.
- R2: The leading leg uses its own dead-band `dl`. `lead_hi` is high when the position p satisfies dl ≤ p < PERIOD/2. `lead_lo` is high when PERIOD/2 + dl ≤ p < PERIOD.
- R3: The lagging leg uses the shifted position s = (p − ph) mod PERIOD, where ph is the active phase, together with its own dead-band `dg`. `lag_hi` is high when dg ≤ s < PERIOD/2. `lag_lo` is high when PERIOD/2 + dg ≤ s.
- R4: A phase input at or above PERIOD is treated as PERIOD−1.
- R5: The phase and both dead-band inputs are captured only on the clock edge that makes the position 0. Changes at any other time have no effect on the outputs until the next such edge.
- R6: While enable is low, all four gate outputs and `sync_trig` are low. The first cycle after enable is taken high is position 0, using the input values present on that edge.
- R7: `lead_hi` and `lead_lo` are never high together, and neither are `lag_hi` and `lag_lo`.
- R8: The two dead-band values act independently. Each one shapes only its own leg.
- R9: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| phase_in | input | CNT_W | Requested lag of the second leg, in counts |
| db_lead_in | input | DB_W | Rising-edge delay for the leading leg |
| db_lag_in | input | DB_W | Rising-edge delay for the lagging leg |
| lead_hi | output | 1 | Leading leg, high-side gate |
| lead_lo | output | 1 | Leading leg, low-side gate |
| lag_hi | output | 1 | Lagging leg, high-side gate |
| lag_lo | output | 1 | Lagging leg, low-side gate |
| sync_trig | output | 1 | One-cycle pulse at each period start |

## Verification
The bench builds the block with PERIOD = 20 and DB_W = 3, which makes CNT_W equal to 5. With these values, phase codes 20 to 31 fall into the clamp range. The largest dead-band (7) comes close to the half period (10), and a run of a few thousand cycles crosses hundreds of period boundaries. That makes mid-period input changes, enable drops at every position, and shifts that wrap the lagging leg across the period end all common rather than rare.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  localparam int NUM_LEGS = 2;

  typedef enum logic [0:0] {
    LEG_LEAD = 1'b0,
    LEG_LAG  = 1'b1
  } leg_id_e;
endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int PERIOD = 500,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] pos_nxt,
  output logic             start_nxt,
  output logic             trig
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             trig_q;
  logic             trig_d;

  // next state: idle holds zero, first enabled cycle is position zero
  always_comb begin
    if (!en) begin
      pos_nxt = '0;
    end else if (!run_q || (cnt_q == LAST)) begin
      pos_nxt = '0;
    end else begin
      pos_nxt = cnt_q + CNT_W'(1);
    end
    start_nxt = (pos_nxt == '0);
    trig_d    = en && start_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= pos_nxt;
      run_q  <= en;
      trig_q <= trig_d;
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/psfb_shadow.sv
module psfb_shadow #(
  parameter int PERIOD = 500,
  parameter int CNT_W  = $clog2(PERIOD),
  parameter int DB_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [DB_W-1:0]  db_lead_in,
  input  logic [DB_W-1:0]  db_lag_in,
  output logic [CNT_W-1:0] ph_nxt,
  output logic [DB_W-1:0]  dbl_nxt,
  output logic [DB_W-1:0]  dbg_nxt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] ph_q;
  logic [DB_W-1:0]  dbl_q;
  logic [DB_W-1:0]  dbg_q;
  logic [CNT_W-1:0] ph_clamped;

  always_comb begin
    ph_clamped = (phase_in > LAST) ? LAST : phase_in;
    if (load) begin
      ph_nxt  = ph_clamped;
      dbl_nxt = db_lead_in;
      dbg_nxt = db_lag_in;
    end else begin
      ph_nxt  = ph_q;
      dbl_nxt = dbl_q;
      dbg_nxt = dbg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      dbl_q <= '0;
      dbg_q <= '0;
    end else if (load) begin
      ph_q  <= ph_nxt;
      dbl_q <= dbl_nxt;
      dbg_q <= dbg_nxt;
    end
  end
endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
  parameter int PERIOD = 500,
  parameter int CNT_W  = $clog2(PERIOD),
  parameter int DB_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] shift_i,
  input  logic [DB_W-1:0]  db_i,
  output logic             hi,
  output logic             lo
);
  localparam int          XW     = CNT_W + 1;
  localparam logic [XW-1:0] PER_X  = XW'(PERIOD);
  localparam logic [XW-1:0] HALF_X = XW'(PERIOD / 2);

  logic [XW-1:0] pos_x;
  logic [XW-1:0] sh_x;
  logic [XW-1:0] db_x;
  logic [XW-1:0] s_x;
  logic          hi_d;
  logic          lo_d;
  logic          hi_q;
  logic          lo_q;

  // leg position relative to its own period start, then dead-band windows
  always_comb begin
    pos_x = {1'b0, pos_i};
    sh_x  = {1'b0, shift_i};
    db_x  = XW'(db_i);
    s_x   = (pos_x >= sh_x) ? (pos_x - sh_x) : (pos_x + PER_X - sh_x);
    hi_d  = en && (s_x >= db_x) && (s_x < HALF_X);
    lo_d  = en && (s_x >= (HALF_X + db_x));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm #(
  parameter int PERIOD = 500,
  parameter int DB_W   = 6,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [DB_W-1:0]  db_lead_in,
  input  logic [DB_W-1:0]  db_lag_in,
  output logic             lead_hi,
  output logic             lead_lo,
  output logic             lag_hi,
  output logic             lag_lo,
  output logic             sync_trig
);
  import psfb_pkg::*;

  logic [CNT_W-1:0] pos_nxt;
  logic             start_nxt;
  logic [CNT_W-1:0] ph_nxt;
  logic [DB_W-1:0]  dbl_nxt;
  logic [DB_W-1:0]  dbg_nxt;

  logic [CNT_W-1:0] shift_a [NUM_LEGS];
  logic [DB_W-1:0]  db_a    [NUM_LEGS];
  logic             hi_a    [NUM_LEGS];
  logic             lo_a    [NUM_LEGS];

  psfb_timebase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pos_nxt   (pos_nxt),
    .start_nxt (start_nxt),
    .trig      (sync_trig)
  );

  psfb_shadow #(.PERIOD(PERIOD), .CNT_W(CNT_W), .DB_W(DB_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_nxt),
    .phase_in   (phase_in),
    .db_lead_in (db_lead_in),
    .db_lag_in  (db_lag_in),
    .ph_nxt     (ph_nxt),
    .dbl_nxt    (dbl_nxt),
    .dbg_nxt    (dbg_nxt)
  );

  assign shift_a[LEG_LEAD] = '0;
  assign shift_a[LEG_LAG]  = ph_nxt;
  assign db_a[LEG_LEAD]    = dbl_nxt;
  assign db_a[LEG_LAG]     = dbg_nxt;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(.PERIOD(PERIOD), .CNT_W(CNT_W), .DB_W(DB_W)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .pos_i   (pos_nxt),
      .shift_i (shift_a[g]),
      .db_i    (db_a[g]),
      .hi      (hi_a[g]),
      .lo      (lo_a[g])
    );
  end

  assign lead_hi = hi_a[LEG_LEAD];
  assign lead_lo = lo_a[LEG_LEAD];
  assign lag_hi  = hi_a[LEG_LAG];
  assign lag_lo  = lo_a[LEG_LAG];
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic lead_hi,
  input logic lead_lo,
  input logic lag_hi,
  input logic lag_lo,
  input logic sync_trig
);
  p_lead_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_hi && lead_lo));

  p_lag_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lag_hi && lag_lo));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(lead_hi || lead_lo || lag_hi || lag_lo || sync_trig));

  p_trig_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_trig |=> !sync_trig);

  p_trig_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_trig |-> $past(en));
endmodule

bind psfb_pwm psfb_pwm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .lead_hi   (lead_hi),
  .lead_lo   (lead_lo),
  .lag_hi    (lag_hi),
  .lag_lo    (lag_lo),
  .sync_trig (sync_trig)
);

// File: tb/psfb_pwm_tb.sv
module psfb_pwm_tb;
  localparam int P     = 20;
  localparam int DBW   = 3;
  localparam int CW    = $clog2(P);
  localparam int HALF  = P / 2;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [CW-1:0] phase_in;
  logic [DBW-1:0] db_lead_in;
  logic [DBW-1:0] db_lag_in;
  logic lead_hi, lead_lo, lag_hi, lag_lo, sync_trig;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  string tag = "R2";

  psfb_pwm #(.PERIOD(P), .DB_W(DBW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .phase_in(phase_in),
    .db_lead_in(db_lead_in), .db_lag_in(db_lag_in),
    .lead_hi(lead_hi), .lead_lo(lead_lo), .lag_hi(lag_hi),
    .lag_lo(lag_lo), .sync_trig(sync_trig)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  int m_pos, m_ph, m_dl, m_dg;

  function automatic bit f_hi(int s, int d);
    return (s >= d) && (s < HALF);
  endfunction
  function automatic bit f_lo(int s, int d);
    return s >= HALF + d;
  endfunction
  function automatic int f_clamp(int ph);
    return (ph >= P) ? P - 1 : ph;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = -1;
    end else if (!en) begin
      m_pos = -1;
    end else begin
      if (m_pos == -1 || m_pos == P - 1) m_pos = 0;
      else m_pos = m_pos + 1;
      if (m_pos == 0) begin
        m_ph = f_clamp(int'(phase_in));
        m_dl = int'(db_lead_in);
        m_dg = int'(db_lag_in);
      end
    end
  end

  task automatic chk(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] act=%0b exp=%0b pos=%0d t=%0t", what, tag, act, exp, m_pos, $time);
    end
  endtask

  task automatic cycle();
    int s;
    bit e_lh, e_ll, e_gh, e_gl, e_t;
    @(negedge clk);
    if (m_pos < 0) begin
      e_lh = 0; e_ll = 0; e_gh = 0; e_gl = 0; e_t = 0;
    end else begin
      s    = (m_pos - m_ph + P) % P;
      e_lh = f_hi(m_pos, m_dl);
      e_ll = f_lo(m_pos, m_dl);
      e_gh = f_hi(s, m_dg);
      e_gl = f_lo(s, m_dg);
      e_t  = (m_pos == 0);
    end
    chk("R1 sync_trig", sync_trig, e_t);
    chk("R2 lead_hi", lead_hi, e_lh);
    chk("R2 lead_lo", lead_lo, e_ll);
    chk("R3 lag_hi", lag_hi, e_gh);
    chk("R3 lag_lo", lag_lo, e_gl);
    chk("R7 overlap", (lead_hi & lead_lo) | (lag_hi & lag_lo), 1'b0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_0420);
    rst_n = 0; en = 0; phase_in = '0; db_lead_in = '0; db_lag_in = '0;
    repeat (3) begin
      @(negedge clk);
      tag = "R9";
      chk("R9 reset lead", lead_hi | lead_lo, 1'b0);
      chk("R9 reset lag", lag_hi | lag_lo, 1'b0);
      chk("R9 reset trig", sync_trig, 1'b0);
    end
    rst_n = 1;
    run(2);

    // basic shifted operation
    tag = "R2/R3";
    phase_in = 5; db_lead_in = 2; db_lag_in = 3; en = 1;
    run(3 * P);

    // clamp of out-of-range phase, and extreme phases
    tag = "R4";
    phase_in = 31;
    run(3 * P);
    phase_in = 20;
    run(2 * P);
    phase_in = 0;
    run(2 * P);
    phase_in = 19;
    run(2 * P);

    // independent dead-bands at extremes
    tag = "R8";
    phase_in = 7; db_lead_in = 0; db_lag_in = 7;
    run(2 * P);
    db_lead_in = 7; db_lag_in = 0;
    run(2 * P);

    // mid-period changes must wait for the next period start
    tag = "R5";
    for (int i = 0; i < 8 * P; i++) begin
      cycle();
      phase_in   = CW'($urandom_range(0, 31));
      db_lead_in = DBW'($urandom_range(0, 7));
      db_lag_in  = DBW'($urandom_range(0, 7));
    end

    // enable drops at assorted positions
    tag = "R6";
    for (int k = 0; k < 30; k++) begin
      run($urandom_range(1, 2 * P));
      en = 0;
      run($urandom_range(1, 4));
      phase_in = CW'($urandom_range(0, 31));
      en = 1;
    end

    // mixed random
    tag = "R5/R6";
    for (int i = 0; i < 4000; i++) begin
      cycle();
      if ($urandom_range(0, 99) == 0) en = ~en;
      if ($urandom_range(0, 3) == 0) phase_in   = CW'($urandom_range(0, 31));
      if ($urandom_range(0, 7) == 0) db_lead_in = DBW'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) db_lag_in  = DBW'($urandom_range(0, 7));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule